// File: doc/BRIEF.md
# Link Rate Fallback Selector

This block chooses the lane count and per-lane rate code for each successive attempt of a display link training run. It walks a fixed candidate list that interleaves lane counts and rate codes in descending order of total bandwidth. On a start pulse it samples the sink's lane and rate capabilities, clamps them to the encoder's own limits, picks a starting point in the list and presents the first candidate the sink can carry. The training logic answers each attempt with a pass or a fail. A fail moves the search on to the next candidate the sink supports. A pass ends the search and holds the chosen configuration.

For each attempt the block also forms the two bytes written to the sink's link configuration: the rate code, and the lane count with an enhanced-framing flag. An optional required payload rate moves the starting point down the list, to the slowest candidate that still carries the payload after 8b/10b coding overhead.

The controller has five states. IDLE waits for start. SEEK looks at the candidate under the index: it skips an unsupported candidate (transition *skip*), presents a supported one (transition *offer*, to TRY), or runs off the end of the list (transition *run_out*, to EXHAUST). TRY holds the candidate until the attempt result arrives: *accept* goes to PASS, and *reject* goes back to SEEK with the index advanced. PASS and EXHAUST each last one cycle, assert done, and return to IDLE (transition *report*).

Top module: `link_rate_fallback`

## Requirements
- R1: The candidate list, indexed 0 to 8 as (rate code, lanes), is (0x14,4), (0x0a,4), (0x14,2), (0x06,4), (0x0a,2), (0x14,1), (0x06,2), (0x0a,1), (0x06,1). When no required rate is given, the search starts at index 0 and visits the list in this order.
- R2: On an accepted start, the lane limit is set to the minimum of `sink_lane_byte[4:0]` and `enc_max_lanes`, and the rate limit to the minimum of `sink_max_rate` and `enc_max_rate`. Bits 7:5 of `sink_lane_byte` are ignored. Every capability input, the enhanced-framing bit and the required rate are sampled only at that start.
- R3: A candidate is skipped, and never presented, when its lane count exceeds the lane limit or its rate code exceeds the rate limit.
- R4: While `try_valid` is high, `bw_code` and `sink_cfg0` equal the candidate's rate code. `lane_count` and `sink_cfg1[4:0]` equal its lane count. `sink_cfg1[7]` equals the sampled enhanced-framing bit, and `sink_cfg1[6:5]` are 0.
- R5: When `req_rate_valid` is high at start, the search starts at index k. Here k is the number of list positions 1 to 8 whose total (rate code × 27000 × lanes) is at least (req_rate / 8, rounded down) × 10.
- R6: A fail result while `try_valid` is high advances the search to the next supported candidate later in the list.
- R7: When no supported candidate remains, done pulses for one cycle with `exhausted` high and `success` low, and no further attempt is presented. This includes the case where no attempt at all is presented.
- R8: A pass result while `try_valid` is high pulses done for one cycle with `success` high. The chosen `lane_count`, `bw_code` and `sink_cfg0/1` then hold until the next accepted start.
- R9: `busy` is high from the cycle after an accepted start until the cycle after done. A start pulse while `busy` is high is ignored, and the sequence of candidates is unaffected.
- R10: After reset, `busy`, `try_valid`, `done`, `success` and `exhausted` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (only accepted when idle) |
| sink_lane_byte | input | 8 | Sink capability byte; low 5 bits give max lanes |
| sink_max_rate | input | 8 | Sink maximum rate code |
| enc_max_lanes | input | 5 | Encoder lane limit |
| enc_max_rate | input | 8 | Encoder rate code limit |
| enh_frame_cap | input | 1 | Sink supports enhanced framing |
| req_rate_valid | input | 1 | A required payload rate is given |
| req_rate | input | 32 | Required payload rate, kB/s |
| attempt_pass | input | 1 | Current attempt trained successfully |
| attempt_fail | input | 1 | Current attempt failed |
| busy | output | 1 | Search in progress |
| try_valid | output | 1 | A candidate is presented for training |
| lane_count | output | 3 | Candidate lane count |
| bw_code | output | 8 | Candidate rate code |
| sink_cfg0 | output | 8 | First sink configuration byte |
| sink_cfg1 | output | 8 | Second sink configuration byte |
| done | output | 1 | One-cycle result pulse |
| success | output | 1 | Last search ended with a pass |
| exhausted | output | 1 | Last search ran out of candidates |

## Verification
The assertions assume that `attempt_pass` and `attempt_fail` are never both high, and that results arrive only while a candidate is presented. The stimulus answers every attempt with exactly one of them, on the cycle the candidate appears. The randomized cases draw sink and encoder limits from the list's own lane counts and rate codes, and also from arbitrary values. They put junk in the upper bits of the lane byte and sometimes give a required rate near the list's totals. Directed cases cover:
- an empty supported set;
- a required rate that exactly meets a total;
- a start pulse with different capabilities in the middle of a search.

// File: rtl/lrf_pkg.sv
package lrf_pkg;

    localparam int NUM_CAND = 9;
    localparam int IDX_W    = 4;
    localparam int LANES_W  = 3;
    localparam int TOT_W    = 40;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEEK,
        ST_TRY,
        ST_PASS,
        ST_EXHAUST
    } lrf_state_e;

    // Rate code of each list position, fastest total first.
    function automatic logic [7:0] cand_code(input logic [IDX_W-1:0] idx);
        unique case (idx)
            4'd0, 4'd2, 4'd5: cand_code = 8'h14;
            4'd1, 4'd4, 4'd7: cand_code = 8'h0a;
            4'd3, 4'd6, 4'd8: cand_code = 8'h06;
            default:          cand_code = 8'h00;
        endcase
    endfunction

    function automatic logic [LANES_W-1:0] cand_lanes(input logic [IDX_W-1:0] idx);
        unique case (idx)
            4'd0, 4'd1, 4'd3: cand_lanes = 3'd4;
            4'd2, 4'd4, 4'd6: cand_lanes = 3'd2;
            4'd5, 4'd7, 4'd8: cand_lanes = 3'd1;
            default:          cand_lanes = 3'd0;
        endcase
    endfunction

    function automatic logic [TOT_W-1:0] cand_total(input logic [IDX_W-1:0] idx,
                                                    input int unsigned unit_kbps);
        cand_total = TOT_W'(cand_code(idx)) * TOT_W'(unit_kbps) * TOT_W'(cand_lanes(idx));
    endfunction

endpackage

// File: rtl/lrf_cap_clamp.sv
module lrf_cap_clamp #(
    parameter int LANE_W = 5,
    parameter int RATE_W = 8
) (
    input  logic [7:0]        sink_lane_byte,
    input  logic [RATE_W-1:0] sink_max_rate,
    input  logic [LANE_W-1:0] enc_max_lanes,
    input  logic [RATE_W-1:0] enc_max_rate,
    output logic [LANE_W-1:0] lim_lanes,
    output logic [RATE_W-1:0] lim_rate
);
    logic [LANE_W-1:0] sink_lanes;

    assign sink_lanes = sink_lane_byte[LANE_W-1:0];

    always_comb begin
        lim_lanes = (sink_lanes > enc_max_lanes) ? enc_max_lanes : sink_lanes;
        lim_rate  = (sink_max_rate > enc_max_rate) ? enc_max_rate : sink_max_rate;
    end
endmodule

// File: rtl/lrf_start_index.sv
module lrf_start_index
    import lrf_pkg::*;
#(
    parameter int          REQ_W     = 32,
    parameter int unsigned UNIT_KBPS = 27000
) (
    input  logic             req_rate_valid,
    input  logic [REQ_W-1:0] req_rate,
    output logic [IDX_W-1:0] start_idx
);
    localparam int NUM_LATER = NUM_CAND - 1;

    logic [TOT_W-1:0]     coded_rate;
    logic [NUM_LATER-1:0] meets;

    // Payload rate grown by the 10/8 line-coding overhead.
    assign coded_rate = TOT_W'(req_rate >> 3) * TOT_W'(10);

    // One compare per list position after the first; totals descend.
    for (genvar g = 1; g < NUM_CAND; g++) begin : g_meet
        localparam logic [TOT_W-1:0] TOTAL = cand_total(IDX_W'(g), UNIT_KBPS);
        assign meets[g-1] = (TOTAL >= coded_rate);
    end

    assign start_idx = req_rate_valid ? IDX_W'($countones(meets)) : '0;
endmodule

// File: rtl/lrf_cand_table.sv
module lrf_cand_table
    import lrf_pkg::*;
#(
    parameter int LANE_W = 5,
    parameter int RATE_W = 8
) (
    input  logic [IDX_W-1:0]   idx,
    input  logic [LANE_W-1:0]  lim_lanes,
    input  logic [RATE_W-1:0]  lim_rate,
    output logic [RATE_W-1:0]  code,
    output logic [LANES_W-1:0] lanes,
    output logic               in_range,
    output logic               supported
);
    always_comb begin
        code      = RATE_W'(cand_code(idx));
        lanes     = cand_lanes(idx);
        in_range  = (idx < IDX_W'(NUM_CAND));
        supported = in_range
                  && (LANE_W'(lanes) <= lim_lanes)
                  && (code <= lim_rate);
    end
endmodule

// File: rtl/link_rate_fallback.sv
module link_rate_fallback
    import lrf_pkg::*;
#(
    parameter int          LANE_W    = 5,
    parameter int          RATE_W    = 8,
    parameter int          REQ_W     = 32,
    parameter int unsigned UNIT_KBPS = 27000,
    parameter int          ENH_BIT   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [7:0]         sink_lane_byte,
    input  logic [RATE_W-1:0]  sink_max_rate,
    input  logic [LANE_W-1:0]  enc_max_lanes,
    input  logic [RATE_W-1:0]  enc_max_rate,
    input  logic               enh_frame_cap,
    input  logic               req_rate_valid,
    input  logic [REQ_W-1:0]   req_rate,
    input  logic               attempt_pass,
    input  logic               attempt_fail,
    output logic               busy,
    output logic               try_valid,
    output logic [LANES_W-1:0] lane_count,
    output logic [RATE_W-1:0]  bw_code,
    output logic [7:0]         sink_cfg0,
    output logic [7:0]         sink_cfg1,
    output logic               done,
    output logic               success,
    output logic               exhausted
);
    lrf_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [LANE_W-1:0] lim_lanes_q, lim_lanes_in;
    logic [RATE_W-1:0] lim_rate_q, lim_rate_in;
    logic              enh_q;
    logic              success_q, exhausted_q;
    logic [IDX_W-1:0]  first_idx;

    logic [RATE_W-1:0]  cur_code;
    logic [LANES_W-1:0] cur_lanes;
    logic               cur_in_range, cur_supported;
    logic               accept_start;

    lrf_cap_clamp #(.LANE_W(LANE_W), .RATE_W(RATE_W)) u_clamp (
        .sink_lane_byte (sink_lane_byte),
        .sink_max_rate  (sink_max_rate),
        .enc_max_lanes  (enc_max_lanes),
        .enc_max_rate   (enc_max_rate),
        .lim_lanes      (lim_lanes_in),
        .lim_rate       (lim_rate_in)
    );

    lrf_start_index #(.REQ_W(REQ_W), .UNIT_KBPS(UNIT_KBPS)) u_start (
        .req_rate_valid (req_rate_valid),
        .req_rate       (req_rate),
        .start_idx      (first_idx)
    );

    lrf_cand_table #(.LANE_W(LANE_W), .RATE_W(RATE_W)) u_table (
        .idx       (idx_q),
        .lim_lanes (lim_lanes_q),
        .lim_rate  (lim_rate_q),
        .code      (cur_code),
        .lanes     (cur_lanes),
        .in_range  (cur_in_range),
        .supported (cur_supported)
    );

    assign accept_start = (state_q == ST_IDLE) && start;

    // Next-state and index selection
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_SEEK;
                    idx_d   = first_idx;
                end
            end
            ST_SEEK: begin
                if (!cur_in_range) begin
                    state_d = ST_EXHAUST;              // run_out
                end else if (cur_supported) begin
                    state_d = ST_TRY;                  // offer
                end else begin
                    idx_d   = idx_q + IDX_W'(1);       // skip
                end
            end
            ST_TRY: begin
                if (attempt_pass) begin
                    state_d = ST_PASS;                 // accept
                end else if (attempt_fail) begin
                    state_d = ST_SEEK;                 // reject
                    idx_d   = idx_q + IDX_W'(1);
                end
            end
            ST_PASS, ST_EXHAUST: state_d = ST_IDLE;    // report
            default:             state_d = ST_IDLE;
        endcase
    end

    // State register, search index and sampled limits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            idx_q       <= '0;
            lim_lanes_q <= '0;
            lim_rate_q  <= '0;
            enh_q       <= 1'b0;
            success_q   <= 1'b0;
            exhausted_q <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (accept_start) begin
                lim_lanes_q <= lim_lanes_in;
                lim_rate_q  <= lim_rate_in;
                enh_q       <= enh_frame_cap;
                success_q   <= 1'b0;
                exhausted_q <= 1'b0;
            end else begin
                if (state_d == ST_PASS)    success_q   <= 1'b1;
                if (state_d == ST_EXHAUST) exhausted_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        try_valid  = (state_q == ST_TRY);
        done       = (state_q == ST_PASS) || (state_q == ST_EXHAUST);
        success    = success_q;
        exhausted  = exhausted_q;
        lane_count = cur_lanes;
        bw_code    = cur_code;
        sink_cfg0  = 8'(cur_code);
        sink_cfg1  = '0;
        sink_cfg1[LANES_W-1:0] = cur_lanes;
        sink_cfg1[ENH_BIT]     = enh_q;
    end

    // R3
    try_supported_chk: assert property (@(posedge clk) disable iff (!rst_n)
        try_valid |-> (LANE_W'(lane_count) <= lim_lanes_q) && (bw_code <= lim_rate_q));

    // R6
    fail_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (try_valid && !attempt_pass && attempt_fail) |=> (state_q == ST_SEEK) && (idx_q == $past(idx_q) + IDX_W'(1)));

    // R8
    pass_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (try_valid && attempt_pass) |=> done && success && !exhausted);

    // R8
    pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASS) |=> $stable(idx_q) && success);

    // R7
    exhaust_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXHAUST) |-> (idx_q == IDX_W'(NUM_CAND)) && exhausted && !success);

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(lim_lanes_q) && $stable(lim_rate_q) && $stable(enh_q));

    // R5
    start_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_start |=> (idx_q < IDX_W'(NUM_CAND)) && busy);

    // R7
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(success && exhausted));
endmodule

// File: tb/link_rate_fallback_test.sv
module link_rate_fallback_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  sink_lane_byte = '0;
    logic [7:0]  sink_max_rate = '0;
    logic [4:0]  enc_max_lanes = '0;
    logic [7:0]  enc_max_rate = '0;
    logic        enh_frame_cap = 1'b0;
    logic        req_rate_valid = 1'b0;
    logic [31:0] req_rate = '0;
    logic        attempt_pass = 1'b0;
    logic        attempt_fail = 1'b0;
    logic        busy, try_valid, done, success, exhausted;
    logic [2:0]  lane_count;
    logic [7:0]  bw_code, sink_cfg0, sink_cfg1;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_rate_fallback uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .sink_lane_byte(sink_lane_byte), .sink_max_rate(sink_max_rate),
        .enc_max_lanes(enc_max_lanes), .enc_max_rate(enc_max_rate),
        .enh_frame_cap(enh_frame_cap), .req_rate_valid(req_rate_valid),
        .req_rate(req_rate), .attempt_pass(attempt_pass), .attempt_fail(attempt_fail),
        .busy(busy), .try_valid(try_valid), .lane_count(lane_count),
        .bw_code(bw_code), .sink_cfg0(sink_cfg0), .sink_cfg1(sink_cfg1),
        .done(done), .success(success), .exhausted(exhausted)
    );

    // Expected list from R1
    function automatic logic [7:0] ref_code(input int i);
        logic [7:0] t [9] = '{8'h14, 8'h0a, 8'h14, 8'h06, 8'h0a, 8'h14, 8'h06, 8'h0a, 8'h06};
        return t[i];
    endfunction

    function automatic int ref_lanes(input int i);
        int t [9] = '{4, 4, 2, 4, 2, 1, 2, 1, 1};
        return t[i];
    endfunction

    // R5 starting point
    function automatic int ref_start(input logic v, input logic [31:0] r);
        longint coded = longint'(r / 8) * 10;
        int k = 0;
        if (!v) return 0;
        for (int i = 1; i < 9; i++)
            if (longint'(ref_code(i)) * 27000 * ref_lanes(i) >= coded) k++;
        return k;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_case(input logic [7:0] slb, input logic [7:0] smr,
                            input logic [4:0] eml, input logic [7:0] emr,
                            input logic enh, input logic rv, input logic [31:0] rr,
                            input int pass_at, input bit poke);
        int seq [9];
        int n = 0;
        int j = 0;
        int guard = 0;
        int lim_l = (int'(slb[4:0]) < int'(eml)) ? int'(slb[4:0]) : int'(eml);   // R2
        int lim_r = (int'(smr) < int'(emr)) ? int'(smr) : int'(emr);
        bit fin = 0;
        int hold_l = 0;
        int hold_c = 0;
        for (int i = ref_start(rv, rr); i < 9; i++)
            if (ref_lanes(i) <= lim_l && int'(ref_code(i)) <= lim_r) begin    // R3
                seq[n] = i;
                n++;
            end
        sink_lane_byte = slb; sink_max_rate = smr; enc_max_lanes = eml;
        enc_max_rate = emr; enh_frame_cap = enh; req_rate_valid = rv; req_rate = rr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9 busy after start", busy, 1);
        while (!fin && guard < 100) begin
            guard++;
            attempt_pass = 1'b0;
            attempt_fail = 1'b0;
            start = 1'b0;
            if (try_valid) begin
                if (j >= n) begin
                    check("R7 attempt beyond list", j, n - 1);
                    attempt_fail = 1'b1;
                end else begin
                    check("R1 R6 lane count", lane_count, ref_lanes(seq[j]));
                    check("R1 R6 rate code", bw_code, ref_code(seq[j]));
                    check("R4 cfg0", sink_cfg0, ref_code(seq[j]));
                    check("R4 cfg1", sink_cfg1, (int'(enh) << 7) | ref_lanes(seq[j]));
                    hold_l = ref_lanes(seq[j]);
                    hold_c = ref_code(seq[j]);
                    if (j == pass_at) attempt_pass = 1'b1;
                    else              attempt_fail = 1'b1;
                    if (poke && j == 0) begin
                        // R9: start while busy, with other limits
                        start = 1'b1;
                        sink_lane_byte = 8'h04; sink_max_rate = 8'h14;
                        enc_max_lanes = 5'd4; enc_max_rate = 8'h14; enh_frame_cap = ~enh;
                        req_rate_valid = 1'b0;
                    end
                end
                j++;
            end else if (done) begin
                fin = 1;
                if (pass_at < n) begin
                    check("R8 success flag", success, 1);
                    check("R8 exhausted low", exhausted, 0);
                    check("R8 attempts used", j, pass_at + 1);
                end else begin
                    check("R7 exhausted flag", exhausted, 1);
                    check("R7 success low", success, 0);
                    check("R7 attempts used", j, n);
                end
            end
            @(negedge clk);
        end
        attempt_pass = 1'b0;
        attempt_fail = 1'b0;
        start = 1'b0;
        if (!fin) check("R7 R8 search finished", 0, 1);
        check("R9 busy low after result", busy, 0);
        check("R8 done is a single pulse", done, 0);
        if (fin && pass_at < n) begin
            sink_lane_byte = 8'h01; enc_max_rate = 8'h06;
            repeat (3) @(negedge clk);
            check("R8 lane count held", lane_count, hold_l);
            check("R8 rate code held", bw_code, hold_c);
            check("R8 success held", success, 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd5521));
        repeat (3) @(negedge clk);
        // R10
        check("R10 busy", busy, 0);
        check("R10 try_valid", try_valid, 0);
        check("R10 done", done, 0);
        check("R10 success", success, 0);
        check("R10 exhausted", exhausted, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_case(8'h04, 8'h14, 5'd4, 8'h14, 1'b1, 1'b0, 0, 0, 0);          // R1 first entry
        run_case(8'h04, 8'h14, 5'd4, 8'h14, 1'b0, 1'b0, 0, 99, 0);         // R1 R6 R7 full walk
        run_case(8'hE2, 8'h0a, 5'd4, 8'h14, 1'b1, 1'b0, 0, 99, 0);         // R2 R3 junk upper bits
        run_case(8'h04, 8'h14, 5'd1, 8'h06, 1'b0, 1'b0, 0, 99, 0);         // R2 encoder clamp
        run_case(8'h00, 8'h14, 5'd4, 8'h14, 1'b0, 1'b0, 0, 0, 0);          // R7 empty set
        run_case(8'h04, 8'h14, 5'd4, 8'h14, 1'b0, 1'b1, 32'd800000, 99, 0); // R5
        run_case(8'h04, 8'h14, 5'd4, 8'h14, 1'b1, 1'b1, 32'd864000, 0, 0);  // R5 exact total
        run_case(8'h04, 8'h14, 5'd4, 8'h14, 1'b1, 1'b1, 32'd864008, 0, 0);  // R5 just above
        run_case(8'h02, 8'h14, 5'd4, 8'h14, 1'b0, 1'b1, 32'd4000000, 1, 0); // R5 rate beyond list
        run_case(8'h01, 8'h06, 5'd4, 8'h14, 1'b0, 1'b0, 0, 3, 1);           // R9 start while busy
        run_case(8'h04, 8'h0a, 5'd2, 8'h14, 1'b1, 1'b0, 0, 2, 1);           // R9 R8

        for (int t = 0; t < 60; t++) begin
            logic [7:0] codes [3] = '{8'h06, 8'h0a, 8'h14};
            int lset [3] = '{1, 2, 4};
            logic [7:0] slb = {3'($urandom), 5'(lset[$urandom % 3])};
            logic [7:0] smr = codes[$urandom % 3];
            logic [4:0] eml = 5'(lset[$urandom % 3]);
            logic [7:0] emr = codes[$urandom % 3];
            logic rv = 1'($urandom);
            logic [31:0] rr = 32'($urandom % 2000000);
            if ($urandom % 4 == 0) begin
                slb = 8'($urandom);
                smr = 8'($urandom % 32);
            end
            run_case(slb, smr, eml, emr, 1'($urandom), rv, rr,
                     int'($urandom % 11), bit'($urandom % 3 == 0));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule